// File: doc/BRIEF.md
# Speculative Reorder Buffer

This block keeps every in-flight instruction of an out-of-order core in a circular queue in program order. Registers and memory change only when an instruction leaves the queue at its head, which keeps the architectural state sequential and makes exceptions precise. At issue, the rename stage takes a slot at the tail. The slot index it gets back is the tag that reservation stations wait on. When a functional unit finishes, the result broadcast names that tag. The slot is marked done and keeps the value, along with any misprediction or exception flag.

Each cycle the head slot is checked. If it is done and clean, it retires: a register write for arithmetic and load results, or a hand-off to the store buffer for stores. If it is done and flagged, the block raises a one-cycle flush with a redirect address and returns to empty, which discards every younger slot. A lookup port lets the rename stage read the results that are finished but not yet retired, so new consumers get their operands without waiting for commit.

Top module: `spec_rob`

## Requirements
- R1: An accepted issue takes the slot named by `iss_tag`. The tag then advances by one, modulo DEPTH.
- R2: A writeback whose tag names an allocated slot marks that slot done and stores its data, misprediction flag, exception flag and redirect target.
- R3: Retirement follows program order, at most one slot per cycle. While `cmt_valid` is high, the `cmt_*` outputs show the head slot's tag, pc, kind, destination and data.
- R4: Nothing retires while the head slot has not been written back, even if younger slots are done.
- R5: A flag on a slot that is not at the head raises no flush. It takes effect only once every older slot has retired.
- R6: When the head slot is done and flagged, `flush` is high for one cycle and `cmt_valid` stays low. On the next cycle the buffer is empty and `iss_tag` is 0. An issue requested during the flush cycle is dropped.
- R7: `lk_ready` is 1 only when slot `lk_tag` is allocated and done, and `lk_data` then carries its stored result. A slot that has retired reads back as not ready.
- R8: When DEPTH slots are occupied, `iss_ready` is 0. An issue request then changes no slot and does not move the tag. One retirement reopens issue.
- R9: Kind encoding: 0 arithmetic, 1 branch, 2 load, 3 store. `cmt_kind` reports it, so the value 3 routes a retiring result to the store buffer.
- R10: A writeback that names an unallocated slot is ignored, and a slot allocated there later starts as not done.
- R11: `flush_pc` is HANDLER_PC when the exception flag is set, whether or not the misprediction flag is also set. With only the misprediction flag set, it is the stored redirect target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Issue request |
| iss_pc | input | PC_W | Program counter of the issuing instruction |
| iss_kind | input | 2 | Instruction kind (R9 encoding) |
| iss_dst | input | REG_W | Destination register number |
| iss_ready | output | 1 | A slot is free |
| iss_tag | output | TAG_W | Tag the next accepted issue receives |
| wb_valid | input | 1 | Result broadcast valid |
| wb_tag | input | TAG_W | Slot addressed by the broadcast |
| wb_data | input | DATA_W | Result value |
| wb_mispred | input | 1 | Branch was mispredicted |
| wb_fault | input | 1 | Instruction raised an exception |
| wb_target | input | PC_W | Correct branch target |
| cmt_valid | output | 1 | Head slot retires this cycle |
| cmt_tag | output | TAG_W | Tag of the retiring slot |
| cmt_pc | output | PC_W | Program counter of the retiring slot |
| cmt_kind | output | 2 | Kind of the retiring slot |
| cmt_dst | output | REG_W | Destination register of the retiring slot |
| cmt_data | output | DATA_W | Result of the retiring slot |
| flush | output | 1 | Discard all in-flight work |
| flush_pc | output | PC_W | Fetch redirect address during flush |
| lk_tag | input | TAG_W | Slot to read for operand supply |
| lk_ready | output | 1 | Looked-up slot holds a finished result |
| lk_data | output | DATA_W | Looked-up result |

## Verification
The bench builds the block with DEPTH = 8 and HANDLER_PC = 0x100. The small depth means a few issues fill the buffer, so refusal when full, pointer wrap and the wrap-bit full/empty distinction are all reached in short directed runs. The distinct handler address tells an exception redirect apart from a mispredicted-branch target. Writebacks arrive in reverse program order, and some name free slots, to exercise head-only retirement and flag handling.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    K_ALU   = 2'd0,
    K_BR    = 2'd1,
    K_LOAD  = 2'd2,
    K_STORE = 2'd3
  } kind_e;

  typedef struct packed {
    logic done;
    logic mispred;
    logic fault;
  } stat_t;
endpackage

// File: rtl/rob_ptr.sv
module rob_ptr #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W:0]   ptr
);
  logic [W:0] ptr_n;

  always_comb begin
    ptr_n = ptr;
    if (clr)      ptr_n = '0;
    else if (inc) ptr_n = ptr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else        ptr <= ptr_n;
  end
endmodule

// File: rtl/rob_slot.sv
module rob_slot
  import rob_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int DATA_W = 32,
  parameter int REG_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              alloc,
  input  logic              wb,
  input  logic              free,
  input  logic [PC_W-1:0]   in_pc,
  input  logic [1:0]        in_kind,
  input  logic [REG_W-1:0]  in_dst,
  input  logic [DATA_W-1:0] wb_data,
  input  logic              wb_mispred,
  input  logic              wb_fault,
  input  logic [PC_W-1:0]   wb_target,
  output logic              busy,
  output stat_t             stat,
  output logic [PC_W-1:0]   pc,
  output logic [1:0]        kind,
  output logic [REG_W-1:0]  dst,
  output logic [DATA_W-1:0] data,
  output logic [PC_W-1:0]   target
);
  logic  busy_n;
  stat_t stat_n;
  logic  wb_hit;

  assign wb_hit = wb && busy && !alloc;

  always_comb begin
    busy_n = busy;
    if (flush)      busy_n = 1'b0;
    else if (alloc) busy_n = 1'b1;
    else if (free)  busy_n = 1'b0;
  end

  always_comb begin
    stat_n = stat;
    if (alloc)       stat_n = '0;
    else if (wb_hit) stat_n = '{done: 1'b1, mispred: wb_mispred, fault: wb_fault};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      stat <= '0;
    end else begin
      busy <= busy_n;
      stat <= stat_n;
    end
  end

  // payload: no reset, written under explicit enables
  always_ff @(posedge clk) begin
    if (alloc) begin
      pc   <= in_pc;
      kind <= in_kind;
      dst  <= in_dst;
    end
    if (wb_hit) begin
      data   <= wb_data;
      target <= wb_target;
    end
  end
endmodule

// File: rtl/rob_retire.sv
module rob_retire
  import rob_pkg::*;
#(
  parameter int                PC_W       = 32,
  parameter logic [PC_W-1:0]   HANDLER_PC = '0
) (
  input  logic            head_busy,
  input  stat_t           head_stat,
  input  logic [PC_W-1:0] head_target,
  output logic            cmt_go,
  output logic            flush,
  output logic [PC_W-1:0] flush_pc
);
  logic head_done;
  logic flagged;

  assign head_done = head_busy && head_stat.done;
  assign flagged   = head_stat.mispred || head_stat.fault;

  always_comb begin
    cmt_go   = head_done && !flagged;
    flush    = head_done && flagged;
    flush_pc = head_stat.fault ? HANDLER_PC : head_target;
  end
endmodule

// File: rtl/spec_rob.sv
module spec_rob
  import rob_pkg::*;
#(
  parameter int              DEPTH      = 16,
  parameter int              PC_W       = 32,
  parameter int              DATA_W     = 32,
  parameter int              REG_W      = 5,
  parameter logic [PC_W-1:0] HANDLER_PC = 32'h0000_0180,
  localparam int             TAG_W      = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  input  logic [PC_W-1:0]   iss_pc,
  input  logic [1:0]        iss_kind,
  input  logic [REG_W-1:0]  iss_dst,
  output logic              iss_ready,
  output logic [TAG_W-1:0]  iss_tag,
  input  logic              wb_valid,
  input  logic [TAG_W-1:0]  wb_tag,
  input  logic [DATA_W-1:0] wb_data,
  input  logic              wb_mispred,
  input  logic              wb_fault,
  input  logic [PC_W-1:0]   wb_target,
  output logic              cmt_valid,
  output logic [TAG_W-1:0]  cmt_tag,
  output logic [PC_W-1:0]   cmt_pc,
  output logic [1:0]        cmt_kind,
  output logic [REG_W-1:0]  cmt_dst,
  output logic [DATA_W-1:0] cmt_data,
  output logic              flush,
  output logic [PC_W-1:0]   flush_pc,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic              lk_ready,
  output logic [DATA_W-1:0] lk_data
);
  logic [TAG_W:0]   head_ptr, tail_ptr;
  logic [TAG_W-1:0] head_idx, tail_idx;
  logic             full, alloc_en, cmt_go;

  logic              s_busy   [DEPTH];
  stat_t             s_stat   [DEPTH];
  logic [PC_W-1:0]   s_pc     [DEPTH];
  logic [1:0]        s_kind   [DEPTH];
  logic [REG_W-1:0]  s_dst    [DEPTH];
  logic [DATA_W-1:0] s_data   [DEPTH];
  logic [PC_W-1:0]   s_target [DEPTH];

  assign head_idx = head_ptr[TAG_W-1:0];
  assign tail_idx = tail_ptr[TAG_W-1:0];
  assign full     = (head_ptr[TAG_W] != tail_ptr[TAG_W]) && (head_idx == tail_idx);
  assign alloc_en = iss_valid && !full && !flush;

  rob_ptr #(.W(TAG_W)) u_head (
    .clk(clk), .rst_n(rst_n), .clr(flush), .inc(cmt_go), .ptr(head_ptr));
  rob_ptr #(.W(TAG_W)) u_tail (
    .clk(clk), .rst_n(rst_n), .clr(flush), .inc(alloc_en), .ptr(tail_ptr));

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    rob_slot #(.PC_W(PC_W), .DATA_W(DATA_W), .REG_W(REG_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .alloc     (alloc_en && (tail_idx == TAG_W'(i))),
      .wb        (wb_valid && (wb_tag == TAG_W'(i))),
      .free      (cmt_go && (head_idx == TAG_W'(i))),
      .in_pc     (iss_pc),
      .in_kind   (iss_kind),
      .in_dst    (iss_dst),
      .wb_data   (wb_data),
      .wb_mispred(wb_mispred),
      .wb_fault  (wb_fault),
      .wb_target (wb_target),
      .busy      (s_busy[i]),
      .stat      (s_stat[i]),
      .pc        (s_pc[i]),
      .kind      (s_kind[i]),
      .dst       (s_dst[i]),
      .data      (s_data[i]),
      .target    (s_target[i])
    );
  end

  rob_retire #(.PC_W(PC_W), .HANDLER_PC(HANDLER_PC)) u_retire (
    .head_busy  (s_busy[head_idx]),
    .head_stat  (s_stat[head_idx]),
    .head_target(s_target[head_idx]),
    .cmt_go     (cmt_go),
    .flush      (flush),
    .flush_pc   (flush_pc)
  );

  always_comb begin
    iss_ready = !full;
    iss_tag   = tail_idx;
    cmt_valid = cmt_go;
    cmt_tag   = head_idx;
    cmt_pc    = s_pc[head_idx];
    cmt_kind  = s_kind[head_idx];
    cmt_dst   = s_dst[head_idx];
    cmt_data  = s_data[head_idx];
    lk_ready  = s_busy[lk_tag] && s_stat[lk_tag].done;
    lk_data   = s_data[lk_tag];
  end
endmodule

// File: rtl/spec_rob_chk.sv
module spec_rob_chk #(
  parameter int TAG_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             iss_valid,
  input logic             iss_ready,
  input logic [TAG_W-1:0] iss_tag,
  input logic             cmt_valid,
  input logic [TAG_W-1:0] cmt_tag,
  input logic             flush
);
  AST_ISSUE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && iss_ready && !flush |=> iss_tag == $past(iss_tag) + TAG_W'(1)); // R1

  AST_COMMIT_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_valid ##1 cmt_valid |-> cmt_tag == $past(cmt_tag) + TAG_W'(1)); // R3

  AST_NO_COMMIT_ON_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !cmt_valid); // R6

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> iss_ready && !cmt_valid && !flush && iss_tag == '0); // R6

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && !iss_ready |=> iss_tag == $past(iss_tag)); // R8
endmodule

bind spec_rob spec_rob_chk #(.TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
  .iss_tag(iss_tag), .cmt_valid(cmt_valid), .cmt_tag(cmt_tag), .flush(flush));

// File: tb/spec_rob_tb.sv
`timescale 1ns/1ps
module spec_rob_tb;
  localparam int          DEPTH   = 8;
  localparam int          TW      = $clog2(DEPTH);
  localparam logic [31:0] HANDLER = 32'h0000_0100;

  logic clk = 1'b0;
  logic rst_n;
  logic iss_valid; logic [31:0] iss_pc; logic [1:0] iss_kind; logic [4:0] iss_dst;
  logic iss_ready; logic [TW-1:0] iss_tag;
  logic wb_valid; logic [TW-1:0] wb_tag; logic [31:0] wb_data;
  logic wb_mispred, wb_fault; logic [31:0] wb_target;
  logic cmt_valid; logic [TW-1:0] cmt_tag; logic [31:0] cmt_pc;
  logic [1:0] cmt_kind; logic [4:0] cmt_dst; logic [31:0] cmt_data;
  logic flush; logic [31:0] flush_pc;
  logic [TW-1:0] lk_tag; logic lk_ready; logic [31:0] lk_data;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  spec_rob #(.DEPTH(DEPTH), .HANDLER_PC(HANDLER)) u_dut (.*);

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic issue(logic [TW-1:0] exp_tag, logic [31:0] pc, logic [1:0] k, logic [4:0] d);
    check("R1", "iss_tag", 64'(iss_tag), 64'(exp_tag));
    iss_valid = 1'b1; iss_pc = pc; iss_kind = k; iss_dst = d;
    tick();
    iss_valid = 1'b0;
  endtask

  task automatic wb(logic [TW-1:0] t, logic [31:0] d, logic m, logic f, logic [31:0] tgt);
    wb_valid = 1'b1; wb_tag = t; wb_data = d; wb_mispred = m; wb_fault = f; wb_target = tgt;
    tick();
    wb_valid = 1'b0; wb_mispred = 1'b0; wb_fault = 1'b0;
  endtask

  task automatic t_reset();
    check("R8", "iss_ready after reset", 64'(iss_ready), 64'd1);
    check("R1", "iss_tag after reset", 64'(iss_tag), 64'd0);
    check("R4", "cmt_valid after reset", 64'(cmt_valid), 64'd0);
    check("R6", "flush after reset", 64'(flush), 64'd0);
  endtask

  task automatic t_inorder();
    issue(0, 32'h40, 2'd0, 5'd1);
    issue(1, 32'h44, 2'd0, 5'd2);
    issue(2, 32'h48, 2'd3, 5'd3);
    wb(2, 32'd33, 1'b0, 1'b0, '0);
    lk_tag = 2; #1;
    check("R7", "lk_ready done slot", 64'(lk_ready), 64'd1);
    check("R7", "lk_data done slot", 64'(lk_data), 64'd33);
    check("R4", "no commit head pending", 64'(cmt_valid), 64'd0);
    wb(1, 32'd22, 1'b0, 1'b0, '0);
    check("R4", "no commit head pending 2", 64'(cmt_valid), 64'd0);
    wb(0, 32'd11, 1'b0, 1'b0, '0);
    check("R3", "commit 0 valid", 64'(cmt_valid), 64'd1);
    check("R3", "commit 0 tag", 64'(cmt_tag), 64'd0);
    check("R3", "commit 0 pc", 64'(cmt_pc), 64'h40);
    check("R2", "commit 0 data", 64'(cmt_data), 64'd11);
    check("R3", "commit 0 dst", 64'(cmt_dst), 64'd1);
    tick();
    check("R3", "commit 1 tag", 64'(cmt_tag), 64'd1);
    check("R2", "commit 1 data", 64'(cmt_data), 64'd22);
    tick();
    check("R3", "commit 2 valid", 64'(cmt_valid), 64'd1);
    check("R9", "commit 2 store kind", 64'(cmt_kind), 64'd3);
    check("R2", "commit 2 data", 64'(cmt_data), 64'd33);
    tick();
    check("R3", "drained", 64'(cmt_valid), 64'd0);
    lk_tag = 0; #1;
    check("R7", "retired slot not ready", 64'(lk_ready), 64'd0);
  endtask

  task automatic t_stale_wb();
    wb(3, 32'd99, 1'b0, 1'b0, '0);
    issue(3, 32'h50, 2'd2, 5'd4);
    lk_tag = 3; #1;
    check("R10", "fresh slot not done", 64'(lk_ready), 64'd0);
    check("R10", "no commit of fresh slot", 64'(cmt_valid), 64'd0);
    wb(3, 32'd55, 1'b0, 1'b0, '0);
    check("R10", "commit after real wb", 64'(cmt_valid), 64'd1);
    check("R10", "commit data", 64'(cmt_data), 64'd55);
    check("R9", "load kind", 64'(cmt_kind), 64'd2);
    tick();
  endtask

  task automatic t_fault_order();
    issue(4, 32'h60, 2'd0, 5'd5);
    issue(5, 32'h64, 2'd2, 5'd6);
    wb(5, 32'd0, 1'b1, 1'b1, 32'h3000);
    check("R5", "younger fault no flush", 64'(flush), 64'd0);
    wb(4, 32'd77, 1'b0, 1'b0, '0);
    check("R5", "older commits first", 64'(cmt_valid), 64'd1);
    check("R5", "no flush yet", 64'(flush), 64'd0);
    tick();
    check("R6", "flush at head", 64'(flush), 64'd1);
    check("R6", "no commit on flush", 64'(cmt_valid), 64'd0);
    check("R11", "fault wins handler pc", 64'(flush_pc), 64'(HANDLER));
    iss_valid = 1'b1; iss_pc = 32'hBAD0; iss_kind = 2'd0; iss_dst = 5'd9;
    tick();
    iss_valid = 1'b0; #1;
    check("R6", "empty after flush", 64'(iss_tag), 64'd0);
    check("R6", "flush one cycle", 64'(flush), 64'd0);
    check("R6", "issue in flush dropped", 64'(cmt_valid), 64'd0);
    lk_tag = 0; #1;
    check("R6", "slot 0 free after flush", 64'(lk_ready), 64'd0);
  endtask

  task automatic t_full();
    for (int i = 0; i < DEPTH; i++) issue(TW'(i), 32'h80 + 32'(4*i), 2'd0, 5'(i + 7));
    check("R8", "full blocks issue", 64'(iss_ready), 64'd0);
    iss_valid = 1'b1; iss_pc = 32'hDEAD; iss_dst = 5'd31;
    tick();
    iss_valid = 1'b0;
    wb(0, 32'h1234, 1'b0, 1'b0, '0);
    check("R8", "head kept dst", 64'(cmt_dst), 64'd7);
    check("R8", "head kept pc", 64'(cmt_pc), 64'h80);
    tick();
    check("R8", "commit reopens", 64'(iss_ready), 64'd1);
    check("R8", "tag wrapped", 64'(iss_tag), 64'd0);
    wb(1, 32'd0, 1'b1, 1'b0, 32'h2000);
    check("R11", "mispredict target", 64'(flush_pc), 64'h2000);
    check("R6", "mispredict flush", 64'(flush), 64'd1);
    tick();
    lk_tag = 2; #1;
    check("R6", "empty after mispredict", 64'(iss_ready), 64'd1);
    check("R6", "tag reset", 64'(iss_tag), 64'd0);
    check("R7", "younger discarded", 64'(lk_ready), 64'd0);
  endtask

  initial begin
    rst_n = 1'b0; iss_valid = 0; iss_pc = 0; iss_kind = 0; iss_dst = 0;
    wb_valid = 0; wb_tag = 0; wb_data = 0; wb_mispred = 0; wb_fault = 0; wb_target = 0;
    lk_tag = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    t_reset();
    t_inorder();
    t_stale_wb();
    t_fault_order();
    t_full();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(5 * 20000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule